// File: doc/BRIEF.md
# Per-Tile Palette Override Unit

This unit sits on the read path between a video controller and its name-table memory. Its job is to give every background tile its own 2-bit palette number, where normally one number is shared by a 2x2-tile group. The CPU fills two 1024-entry palette banks through a write window at the top of its address space. While the picture is being drawn, the unit watches the controller's tile-name fetches and keeps the 10-bit tile offset of the most recent one. When the matching attribute fetch follows, the unit supplies a replacement byte in the same cycle. That byte holds the stored palette number in each of its four 2-bit fields, so the renderer's shift selection lands on the right value whichever quadrant it picks.

The override applies only when the enable input is high and the access is flagged as a rendering fetch. Every other access returns the name-table memory data unchanged. The palette bank that answers an attribute fetch depends on the mirroring mode in force. Only the two low bits of each CPU write are kept.

Top module: `tile_palette_override`

## Requirements
- R1: A CPU write with `cpu_we` high and `cpu_addr[15:14]` = 2'b11 stores `cpu_wdata[1:0]` into bank `cpu_addr[10]` at entry `cpu_addr[9:0]`. Bits 13:11 and bits 7:2 of the data are don't-care, so the 2 KB window repeats across 0xC000–0xFFFF. Writes outside that range, and cycles with `cpu_we` low, change no entry.
- R2: A tile-name fetch is a cycle with `render_rd` = 1, `ovr_en` = 1, `vid_addr[13]` = 1 and `vid_addr[9:0]` < 0x3C0. At the end of that clock cycle its `vid_addr[9:0]` becomes the latched tile offset. During the fetch itself the output passes the memory data through with `ovr_valid` = 0.
- R3: An attribute fetch is a cycle with `render_rd` = 1, `ovr_en` = 1, `vid_addr[13]` = 1 and `vid_addr[9:0]` ≥ 0x3C0. In that same cycle `ovr_valid` is 1 and `vid_rdata` is the replacement byte for the latched tile offset, with no added cycle of delay.
- R4: The bank read for an attribute fetch follows `mirror_mode`. Encoding 0 (vertical) uses `vid_addr[10]`, encoding 1 (horizontal) uses `vid_addr[11]`, encoding 2 uses bank 0 and encoding 3 uses bank 1.
- R5: The replacement byte is the stored 2-bit value v repeated four times, i.e. {v, v, v, v} across bits 7:6, 5:4, 3:2 and 1:0.
- R6: When `ovr_en` = 0, `render_rd` = 0 or `vid_addr[13]` = 0, `ovr_valid` is 0 and `vid_rdata` equals `mem_rdata`. Such a cycle does not change the latched tile offset.
- R7: Synchronous reset clears the latched tile offset to 0, so an attribute fetch that comes right after reset reads entry 0.
- R8: Attribute fetches leave the latched tile offset alone. Back-to-back attribute fetches therefore answer for the same tile, each from the bank its own address and mode select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data (bits 1:0 kept) |
| vid_addr | input | 14 | Video controller fetch address |
| render_rd | input | 1 | High when the fetch is a rendering read |
| mirror_mode | input | 2 | Mirroring mode: 0 vertical, 1 horizontal, 2 bank 0 only, 3 bank 1 only |
| ovr_en | input | 1 | Enables the per-tile override |
| mem_rdata | input | 8 | Data from the normal name-table memory |
| ovr_valid | output | 1 | High when `vid_rdata` carries a replacement byte |
| vid_rdata | output | 8 | Byte returned to the video controller |

## Verification
The bench builds the unit with its default parameters: 10-bit tile offsets, two banks and the 0x3C0 attribute boundary. It writes all 2048 bank entries through mirrored window addresses, using a pattern in which the two banks differ at every entry. For each of the four mirroring modes it then pairs every one of the 960 tile offsets with an attribute fetch, rotating the name-table quadrant bits. A single wrong bank choice, offset bit or byte field therefore shows up as a mismatch. Directed cases follow for writes that must be ignored, fetches that are disqualified, back-to-back attribute fetches and reset.

// File: rtl/tpo_pkg.sv
package tpo_pkg;

    typedef enum logic [1:0] {
        MIR_VERT  = 2'd0,
        MIR_HORZ  = 2'd1,
        MIR_ONE_A = 2'd2,
        MIR_ONE_B = 2'd3
    } mirror_e;

    typedef enum logic [1:0] {
        FK_PASS = 2'd0,
        FK_TILE = 2'd1,
        FK_ATTR = 2'd2
    } fetch_e;

    typedef struct packed {
        fetch_e kind;
        logic   bank;
    } fetch_info_t;

    localparam int PAL_W = 2;

    function automatic logic pick_bank(mirror_e mode, logic a10, logic a11);
        logic b;
        case (mode)
            MIR_VERT:  b = a10;
            MIR_HORZ:  b = a11;
            MIR_ONE_A: b = 1'b0;
            default:   b = 1'b1;
        endcase
        return b;
    endfunction

    function automatic logic [7:0] spread_palette(logic [PAL_W-1:0] v);
        return {4{v}};
    endfunction

endpackage

// File: rtl/tpo_attr_store.sv
module tpo_attr_store
    import tpo_pkg::*;
#(
    parameter int OFS_W     = 10,
    parameter int CPU_AW    = 16,
    parameter int NUM_BANKS = 2
) (
    input  logic                clk,
    input  logic                cpu_we,
    input  logic [CPU_AW-1:0]   cpu_addr,
    input  logic [7:0]          cpu_wdata,
    input  logic                rd_bank,
    input  logic [OFS_W-1:0]    rd_idx,
    output logic [PAL_W-1:0]    rd_val
);
    localparam int DEPTH = 1 << OFS_W;

    logic             in_window;
    logic             wr_bank;
    logic [OFS_W-1:0] wr_idx;
    logic [PAL_W-1:0] bank_rd [NUM_BANKS];

    assign in_window = (cpu_addr[CPU_AW-1 -: 2] == 2'b11);
    assign wr_bank   = cpu_addr[OFS_W];
    assign wr_idx    = cpu_addr[OFS_W-1:0];

    logic unused_store_bits;
    assign unused_store_bits = ^{cpu_addr[CPU_AW-3:OFS_W+1], cpu_wdata[7:PAL_W]};

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [PAL_W-1:0] cells [DEPTH];
        logic             hit;

        assign hit = cpu_we && in_window && (wr_bank == b[0]);

        always_ff @(posedge clk) begin
            if (hit) begin
                cells[wr_idx] <= cpu_wdata[PAL_W-1:0];
            end
        end

        assign bank_rd[b] = cells[rd_idx];
    end

    assign rd_val = bank_rd[rd_bank];

endmodule

// File: rtl/tpo_fetch_track.sv
module tpo_fetch_track
    import tpo_pkg::*;
#(
    parameter int VADDR_W    = 14,
    parameter int OFS_W      = 10,
    parameter int ATTR_START = 960
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               render_rd,
    input  logic               ovr_en,
    input  logic [VADDR_W-1:0] vid_addr,
    input  logic [1:0]         mirror_mode,
    output fetch_info_t        info,
    output logic [OFS_W-1:0]   tile_ofs
);
    localparam int               NT_BIT   = VADDR_W - 1;
    localparam logic [OFS_W-1:0] ATTR_OFS = OFS_W'(ATTR_START);

    logic             qualified;
    logic [OFS_W-1:0] cur_ofs;

    assign qualified = render_rd && ovr_en && vid_addr[NT_BIT];
    assign cur_ofs   = vid_addr[OFS_W-1:0];

    logic unused_fetch_bits;
    assign unused_fetch_bits = ^vid_addr[NT_BIT-1:OFS_W+2];

    always_comb begin
        info.bank = pick_bank(mirror_e'(mirror_mode), vid_addr[OFS_W], vid_addr[OFS_W+1]);
        if (!qualified) begin
            info.kind = FK_PASS;
        end else if (cur_ofs >= ATTR_OFS) begin
            info.kind = FK_ATTR;
        end else begin
            info.kind = FK_TILE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tile_ofs <= '0;
        end else if (info.kind == FK_TILE) begin
            tile_ofs <= cur_ofs;
        end
    end

endmodule

// File: rtl/tpo_out_mux.sv
module tpo_out_mux
    import tpo_pkg::*;
(
    input  fetch_info_t      info,
    input  logic [PAL_W-1:0] pal,
    input  logic [7:0]       mem_rdata,
    output logic             ovr_valid,
    output logic [7:0]       vid_rdata
);
    always_comb begin
        ovr_valid = (info.kind == FK_ATTR);
        vid_rdata = ovr_valid ? spread_palette(pal) : mem_rdata;
    end

endmodule

// File: rtl/tile_palette_override.sv
module tile_palette_override
    import tpo_pkg::*;
#(
    parameter int VADDR_W    = 14,
    parameter int OFS_W      = 10,
    parameter int CPU_AW     = 16,
    parameter int ATTR_START = 960
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_we,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic [7:0]         cpu_wdata,
    input  logic [VADDR_W-1:0] vid_addr,
    input  logic               render_rd,
    input  logic [1:0]         mirror_mode,
    input  logic               ovr_en,
    input  logic [7:0]         mem_rdata,
    output logic               ovr_valid,
    output logic [7:0]         vid_rdata
);
    fetch_info_t      info;
    logic [OFS_W-1:0] tile_ofs;
    logic [PAL_W-1:0] pal;

    tpo_fetch_track #(
        .VADDR_W    (VADDR_W),
        .OFS_W      (OFS_W),
        .ATTR_START (ATTR_START)
    ) u_track (
        .clk         (clk),
        .rst         (rst),
        .render_rd   (render_rd),
        .ovr_en      (ovr_en),
        .vid_addr    (vid_addr),
        .mirror_mode (mirror_mode),
        .info        (info),
        .tile_ofs    (tile_ofs)
    );

    tpo_attr_store #(
        .OFS_W     (OFS_W),
        .CPU_AW    (CPU_AW),
        .NUM_BANKS (2)
    ) u_store (
        .clk       (clk),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .rd_bank   (info.bank),
        .rd_idx    (tile_ofs),
        .rd_val    (pal)
    );

    tpo_out_mux u_mux (
        .info      (info),
        .pal       (pal),
        .mem_rdata (mem_rdata),
        .ovr_valid (ovr_valid),
        .vid_rdata (vid_rdata)
    );

endmodule

// File: rtl/tpo_checker.sv
module tpo_checker #(
    parameter int VADDR_W    = 14,
    parameter int OFS_W      = 10,
    parameter int ATTR_START = 960
) (
    input logic               clk,
    input logic               rst,
    input logic [VADDR_W-1:0] vid_addr,
    input logic               render_rd,
    input logic               ovr_en,
    input logic [7:0]         mem_rdata,
    input logic               ovr_valid,
    input logic [7:0]         vid_rdata,
    input logic [OFS_W-1:0]   tile_ofs
);
    localparam logic [OFS_W-1:0] ATTR_OFS = OFS_W'(ATTR_START);

    logic qual;
    logic tile_hit;
    assign qual     = render_rd && ovr_en && vid_addr[VADDR_W-1];
    assign tile_hit = qual && (vid_addr[OFS_W-1:0] < ATTR_OFS);

    AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst)
        !ovr_valid |-> (vid_rdata == mem_rdata)); // R6

    AST_SPREAD_FIELDS: assert property (@(posedge clk) disable iff (rst)
        ovr_valid |-> (vid_rdata[7:6] == vid_rdata[1:0] &&
                       vid_rdata[5:4] == vid_rdata[1:0] &&
                       vid_rdata[3:2] == vid_rdata[1:0])); // R5

    AST_VALID_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        ovr_valid |-> (qual && vid_addr[OFS_W-1:0] >= ATTR_OFS)); // R3

    AST_OFS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        tile_hit |=> (tile_ofs == $past(vid_addr[OFS_W-1:0]))); // R2

    AST_OFS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tile_hit |=> $stable(tile_ofs)); // R8

endmodule

bind tile_palette_override tpo_checker #(
    .VADDR_W    (VADDR_W),
    .OFS_W      (OFS_W),
    .ATTR_START (ATTR_START)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .vid_addr  (vid_addr),
    .render_rd (render_rd),
    .ovr_en    (ovr_en),
    .mem_rdata (mem_rdata),
    .ovr_valid (ovr_valid),
    .vid_rdata (vid_rdata),
    .tile_ofs  (tile_ofs)
);

// File: tb/tile_palette_override_bench.sv
module tile_palette_override_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [13:0] vid_addr = '0;
    logic        render_rd = 1'b0;
    logic [1:0]  mirror_mode = 2'd0;
    logic        ovr_en = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        ovr_valid;
    logic [7:0]  vid_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [1:0] model [2][1024];

    always #10 clk = ~clk;

    tile_palette_override u_tile_palette_override (
        .clk         (clk),
        .rst         (rst),
        .cpu_we      (cpu_we),
        .cpu_addr    (cpu_addr),
        .cpu_wdata   (cpu_wdata),
        .vid_addr    (vid_addr),
        .render_rd   (render_rd),
        .mirror_mode (mirror_mode),
        .ovr_en      (ovr_en),
        .mem_rdata   (mem_rdata),
        .ovr_valid   (ovr_valid),
        .vid_rdata   (vid_rdata)
    );

    function automatic logic [1:0] pal_of(int b, int i);
        return 2'((i + (i >> 3) + 2 * b + 1) & 3);
    endfunction

    function automatic int bank_of(logic [1:0] mode, logic [13:0] a);
        case (mode)
            2'd0:    return int'(a[10]);
            2'd1:    return int'(a[11]);
            2'd2:    return 0;
            default: return 1;
        endcase
    endfunction

    task automatic check(string req, logic [8:0] act, logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: valid/data actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_write(logic [15:0] a, logic [7:0] d, logic we);
        @(negedge clk);
        cpu_we = we; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    // A fetch that must pass the memory data through (tile fetch or disqualified).
    task automatic pass_fetch(string req, logic [13:0] a, logic en, logic rd);
        @(negedge clk);
        cpu_we = 1'b0;
        vid_addr = a; ovr_en = en; render_rd = rd;
        mem_rdata = 8'h5A ^ a[7:0] ^ {6'd0, a[11:10]};
        #2;
        check(req, {ovr_valid, vid_rdata}, {1'b0, mem_rdata});
    endtask

    task automatic attr_fetch(string req, logic [13:0] a, logic [7:0] exp);
        @(negedge clk);
        vid_addr = a; ovr_en = 1'b1; render_rd = 1'b1;
        mem_rdata = ~a[7:0];
        #2;
        check(req, {ovr_valid, vid_rdata}, {1'b1, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R6: pass-through right after reset
        pass_fetch("R6 idle", 14'h0000, 1'b0, 1'b0);

        // R1: fill both banks via mirrored window addresses
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < 1024; i++) begin
                logic [15:0] a;
                a = 16'hC000 | 16'(((i * 5 + b) & 7) << 11) | 16'(b << 10) | 16'(i);
                @(negedge clk);
                cpu_we = 1'b1; cpu_addr = a;
                cpu_wdata = {6'((i * 7) & 63), pal_of(b, i)};
                model[b][i] = pal_of(b, i);
            end
        end
        @(negedge clk);
        cpu_we = 1'b0;

        // R2 R3 R4 R5: every tile, every mode
        for (int m = 0; m < 4; m++) begin
            mirror_mode = 2'(m);
            for (int t = 0; t < 960; t++) begin
                logic [13:0] ta, aa;
                int bk;
                ta = 14'h2000 | 14'(((t * 3 + m) & 3) << 10) | 14'(t);
                aa = 14'h2000 | 14'(((t * 3 + m) & 3) << 10) | 14'h3C0 | 14'(t % 64);
                bk = bank_of(2'(m), aa);
                pass_fetch("R2 tile fetch", ta, 1'b1, 1'b1);
                attr_fetch("R4/R5 attr fetch", aa, {4{model[bk][t]}});
            end
        end

        // R8: back-to-back attribute fetches, different quadrants, vertical mode
        mirror_mode = 2'd0;
        pass_fetch("R2 tile 77", 14'h2000 | 14'd77, 1'b1, 1'b1);
        attr_fetch("R8 first attr", 14'h23C5, {4{model[0][77]}});
        attr_fetch("R8 second attr", 14'h27D0, {4{model[1][77]}});
        attr_fetch("R8 third attr", 14'h2BFF, {4{model[0][77]}});

        // R1: writes outside window / with strobe low are ignored
        mirror_mode = 2'd2;
        cpu_write(16'h8005, 8'hFF ^ {6'd0, model[0][5]}, 1'b1);
        cpu_write(16'h4005, 8'hFF ^ {6'd0, model[0][5]}, 1'b1);
        cpu_write(16'hC005, 8'hFF ^ {6'd0, model[0][5]}, 1'b0);
        pass_fetch("R2 tile 5", 14'h2005, 1'b1, 1'b1);
        attr_fetch("R1 ignored writes", 14'h23C0, {4{model[0][5]}});

        // R1: mirrored alias 0xF805 hits bank 0 entry 5; upper data bits dropped
        cpu_write(16'hF805, 8'hFC | ~{6'd0, model[0][5]} & 8'h03, 1'b1);
        model[0][5] = ~model[0][5];
        attr_fetch("R1 mirrored write", 14'h23C0, {4{model[0][5]}});
        // alias 0xDC06: bit 10 set -> bank 1 entry 6
        cpu_write(16'hDC06, 8'h03, 1'b1);
        model[1][6] = 2'd3;
        mirror_mode = 2'd3;
        pass_fetch("R2 tile 6", 14'h2006, 1'b1, 1'b1);
        attr_fetch("R1 bank1 alias", 14'h23C1, 8'hFF);

        // R6: disqualified fetches neither override nor latch
        mirror_mode = 2'd2;
        pass_fetch("R2 tile 40", 14'h2028, 1'b1, 1'b1);
        pass_fetch("R6 enable low tile", 14'h2007, 1'b0, 1'b1);
        pass_fetch("R6 render low tile", 14'h2008, 1'b1, 1'b0);
        pass_fetch("R6 low address tile", 14'h0009, 1'b1, 1'b1);
        pass_fetch("R6 enable low attr", 14'h23C0, 1'b0, 1'b1);
        pass_fetch("R6 render low attr", 14'h23C0, 1'b1, 1'b0);
        pass_fetch("R6 low address attr", 14'h03C0, 1'b1, 1'b1);
        attr_fetch("R6 offset unchanged", 14'h23C0, {4{model[0][40]}});

        // R7: reset clears latched offset
        pass_fetch("R2 tile 9", 14'h2009, 1'b1, 1'b1);
        @(negedge clk);
        render_rd = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        attr_fetch("R7 offset zero after reset", 14'h23C0, {4{model[0][0]}});

        @(negedge clk);
        render_rd = 1'b0; ovr_en = 1'b0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule